// File: doc/BRIEF.md
# Adaptive Memory Traffic Throttler

This block sits between a memory controller's command queue and the DRAM and keeps memory power under a target. Time is cut into back-to-back windows of `WINDOW_LEN` cycles. In each window the block raises `stall_o` for the first T cycles, and the controller sends no traffic to DRAM while that signal is high. The stall decision is a fresh output on every cycle.

T is not fixed. Over a long epoch of `EPOCH_LEN` cycles the block counts read, write and bank-conflict event pulses in saturating counters. On the last cycle of each epoch it captures those counts, the power target and a set of signed fixed-point coefficients, and then clears the counters. A linear model turns the captured values into a new T: a bias plus one weighted term for each of the power target, reads, writes and conflicts. The result is clamped to the window length and goes into service at the next window boundary. The coefficients are fitted offline and only presented on an input. The hardware never adjusts them.

Top module: `mem_throttle`

## Requirements
- R1: After reset, `t_cur_o` is 0 and `stall_o` is low, and both stay so until the first model result goes into service.
- R2: Windows of `WINDOW_LEN` cycles run back to back from the first cycle after reset. `stall_o` is high exactly in the cycles whose position in the window (0 to `WINDOW_LEN`-1) is below `t_cur_o`.
- R3: The model value is floor((c0 + c1*P + c2*Nr + c3*Nw + c4*Nc) / 2^`FRAC_BITS`). The ci are signed two's-complement `COEF_W`-bit slices of `coef_vec_i`: slice i sits at bits [i*`COEF_W` +: `COEF_W`], with slice 0 the bias, 1 the power weight, 2 reads, 3 writes and 4 conflicts. P is the unsigned power target. Nr, Nw and Nc are the epoch's event counts.
- R4: An epoch is `EPOCH_LEN` cycles long, and the first epoch starts on the first cycle after reset. The counts used for an epoch include pulses in its last cycle. The counters then restart from zero, so one epoch's events never reach the next epoch's result.
- R5: Each event count saturates at 2^`CNT_W`-1 and does not wrap.
- R6: A model value below 0 gives T = 0, and a value above `WINDOW_LEN` gives T = `WINDOW_LEN` (stall for the whole window).
- R7: `t_cur_o` changes only at a window boundary. A new result is used from the first window that starts at least 4 cycles after the epoch's last cycle (with `MODEL_PIPE` = 1).
- R8: The power target and the coefficients are sampled only in an epoch's last cycle. Their values in any other cycle have no effect on T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_target_i | input | PWR_W | Unsigned power target |
| rd_evt_i | input | 1 | One-cycle pulse per read issued |
| wr_evt_i | input | 1 | One-cycle pulse per write issued |
| bank_conf_i | input | 1 | One-cycle pulse per bank conflict |
| coef_vec_i | input | 5*COEF_W | Packed signed model coefficients (slice layout in R3) |
| stall_o | output | 1 | Block all controller-to-DRAM traffic this cycle |
| t_cur_o | output | clog2(WINDOW_LEN+1) | Stall length of the current window |

## Verification
The assertions check the window shape on every cycle: the stall is a single prefix that starts at position 0 whenever T is non-zero, T stays inside the window and holds steady within a window, and the counters saturate and clear at epoch ends. Only the bench scenarios can show the arithmetic of the model. This includes the rounding of the shift, the clamps at both ends, and the effect of saturation on a result. The bench scenarios also show the exact window in which a new T first applies, that a pulse in an epoch's last cycle is counted, and that power and coefficient changes in the middle of an epoch are ignored.

// File: rtl/throttle_pkg.sv
package throttle_pkg;

   // number of counted event streams: reads, writes, bank conflicts
   localparam int N_EVT  = 3;
   // model features: power target followed by the event counts
   localparam int N_FEAT = N_EVT + 1;
   // coefficients: one bias plus one weight per feature
   localparam int N_COEF = N_FEAT + 1;

   // event stream positions inside the event vector
   typedef enum int {
      EV_READ  = 0,
      EV_WRITE = 1,
      EV_CONFL = 2
   } evt_slot_e;

   // coefficient slice positions inside the packed coefficient vector
   typedef enum int {
      CF_BIAS   = 0,
      CF_POWER  = 1,
      CF_READS  = 2,
      CF_WRITES = 3,
      CF_CONFL  = 4
   } coef_slot_e;

   // width of a counter able to hold 0 .. n-1 (minimum one bit)
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/throttle_evt_counter.sv
module throttle_evt_counter #(
   parameter int CNT_W    = 20,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_i,
   input  logic             clear_i,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] next_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_inc = (evt_i && (cnt_q != CNT_MAX)) ? cnt_q + 1'b1 : cnt_q;
      end else begin : g_wrap
         assign cnt_inc = cnt_q + CNT_W'(evt_i);
      end
   endgenerate

   // on clear the count including this cycle's pulse leaves on next_o,
   // and the register restarts at zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_inc;
      end
   end

   assign count_o = cnt_q;
   assign next_o  = cnt_inc;

endmodule

// File: rtl/throttle_lin_model.sv
module throttle_lin_model
   import throttle_pkg::*;
#(
   parameter int PWR_W     = 16,
   parameter int CNT_W     = 20,
   parameter int COEF_W    = 16,
   parameter int FRAC_BITS = 8,
   parameter int T_MAX     = 10000,
   parameter int T_W       = 14,
   parameter bit PIPE      = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cap_i,
   input  logic [PWR_W-1:0]               pwr_i,
   input  logic [N_EVT-1:0][CNT_W-1:0]    cnt_i,
   input  logic [N_COEF*COEF_W-1:0]       coef_i,
   output logic [T_W-1:0]                 t_o,
   output logic                           t_vld_o
);

   localparam int IN_W   = (PWR_W > CNT_W) ? PWR_W : CNT_W;
   localparam int FEAT_W = IN_W + 1;
   localparam int PROD_W = COEF_W + FEAT_W;
   localparam int ACC_W  = PROD_W + $clog2(N_COEF) + 1;
   localparam logic signed [ACC_W-1:0] T_MAX_S = ACC_W'(T_MAX);

   if (ACC_W <= T_W + 1) begin : g_bad_acc
      $error("accumulator narrower than the stall length");
   end

   // ---------------- capture stage ----------------
   logic [N_FEAT-1:0][FEAT_W-1:0] feat_q;
   logic [N_COEF-1:0][COEF_W-1:0] coef_q;
   logic                          cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         feat_q <= '0;
         coef_q <= '0;
         cap_q  <= 1'b0;
      end else begin
         cap_q <= cap_i;
         if (cap_i) begin
            feat_q[CF_POWER-1] <= FEAT_W'(pwr_i);
            for (int e = 0; e < N_EVT; e++) begin
               feat_q[e+1] <= FEAT_W'(cnt_i[e]);
            end
            coef_q <= coef_i;
         end
      end
   end

   // ---------------- weighting ----------------
   logic signed [PROD_W-1:0] prod_c [N_FEAT];

   for (genvar g = 0; g < N_FEAT; g++) begin : g_mul
      logic signed [PROD_W-1:0] c_ext;
      logic signed [PROD_W-1:0] f_ext;
      assign c_ext     = PROD_W'($signed(coef_q[g+1]));
      assign f_ext     = $signed(PROD_W'(feat_q[g]));
      assign prod_c[g] = c_ext * f_ext;
   end

   logic signed [PROD_W-1:0] prod_s [N_FEAT];
   logic signed [COEF_W-1:0] bias_s;
   logic                     vld_s;

   if (PIPE) begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < N_FEAT; i++) begin
               prod_s[i] <= '0;
            end
            bias_s <= '0;
            vld_s  <= 1'b0;
         end else begin
            vld_s <= cap_q;
            if (cap_q) begin
               prod_s <= prod_c;
               bias_s <= $signed(coef_q[CF_BIAS]);
            end
         end
      end
   end else begin : g_comb
      assign prod_s = prod_c;
      assign bias_s = $signed(coef_q[CF_BIAS]);
      assign vld_s  = cap_q;
   end

   // ---------------- sum, scale, clamp ----------------
   logic signed [ACC_W-1:0] acc;
   logic signed [ACC_W-1:0] acc_shr;
   logic [T_W-1:0]          t_c;

   always_comb begin
      acc = ACC_W'(bias_s);
      for (int i = 0; i < N_FEAT; i++) begin
         acc = acc + ACC_W'(prod_s[i]);
      end
   end

   assign acc_shr = acc >>> FRAC_BITS;

   always_comb begin
      if (acc_shr[ACC_W-1]) begin
         t_c = '0;
      end else if (acc_shr > T_MAX_S) begin
         t_c = T_W'(T_MAX);
      end else begin
         t_c = T_W'(acc_shr);
      end
   end

   assign t_o     = t_c;
   assign t_vld_o = vld_s;

endmodule

// File: rtl/throttle_window_gen.sv
module throttle_window_gen #(
   parameter int WINDOW_LEN = 10000,
   parameter int T_W        = 14,
   parameter int WIN_W      = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [T_W-1:0]   t_new_i,
   input  logic             t_new_vld_i,
   output logic             stall_o,
   output logic [T_W-1:0]   t_cur_o,
   output logic [WIN_W-1:0] win_pos_o
);

   logic [WIN_W-1:0] win_q;
   logic             win_end;
   logic [T_W-1:0]   t_cur_q;
   logic [T_W-1:0]   t_pend_q;
   logic             pend_q;

   assign win_end = (win_q == WIN_W'(WINDOW_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
      end else if (win_end) begin
         win_q <= '0;
      end else begin
         win_q <= win_q + 1'b1;
      end
   end

   // a pending value enters service only across a window boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_cur_q  <= '0;
         t_pend_q <= '0;
         pend_q   <= 1'b0;
      end else begin
         if (win_end && pend_q) begin
            t_cur_q <= t_pend_q;
         end
         if (t_new_vld_i) begin
            t_pend_q <= t_new_i;
            pend_q   <= 1'b1;
         end else if (win_end) begin
            pend_q <= 1'b0;
         end
      end
   end

   assign stall_o   = (T_W'(win_q) < t_cur_q);
   assign t_cur_o   = t_cur_q;
   assign win_pos_o = win_q;

endmodule

// File: rtl/mem_throttle.sv
module mem_throttle
   import throttle_pkg::*;
#(
   parameter int WINDOW_LEN = 10000,
   parameter int EPOCH_LEN  = 1000000,
   parameter int CNT_W      = 20,
   parameter int PWR_W      = 16,
   parameter int COEF_W     = 16,
   parameter int FRAC_BITS  = 8,
   parameter bit MODEL_PIPE = 1'b1,
   parameter bit SATURATE   = 1'b1,
   localparam int T_W       = $clog2(WINDOW_LEN + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [PWR_W-1:0]          power_target_i,
   input  logic                      rd_evt_i,
   input  logic                      wr_evt_i,
   input  logic                      bank_conf_i,
   input  logic [N_COEF*COEF_W-1:0]  coef_vec_i,
   output logic                      stall_o,
   output logic [T_W-1:0]            t_cur_o
);

   localparam int WIN_W = idx_width(WINDOW_LEN);
   localparam int EP_W  = idx_width(EPOCH_LEN);

   // ---------------- elaboration checks ----------------
   if (WINDOW_LEN < 4) begin : g_bad_win
      $error("WINDOW_LEN must be at least 4");
   end
   if (EPOCH_LEN < WINDOW_LEN) begin : g_bad_epoch
      $error("EPOCH_LEN must not be shorter than WINDOW_LEN");
   end
   if (CNT_W < 1 || PWR_W < 1) begin : g_bad_width
      $error("counter and power widths must be positive");
   end
   if (FRAC_BITS < 0 || FRAC_BITS >= COEF_W) begin : g_bad_frac
      $error("FRAC_BITS must lie in 0 .. COEF_W-1");
   end

   // ---------------- epoch timing ----------------
   logic [EP_W-1:0] ep_q;
   logic            ep_last;

   assign ep_last = (ep_q == EP_W'(EPOCH_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ep_q <= '0;
      end else if (ep_last) begin
         ep_q <= '0;
      end else begin
         ep_q <= ep_q + 1'b1;
      end
   end

   // ---------------- event counters ----------------
   logic [N_EVT-1:0]            evt;
   logic [N_EVT-1:0][CNT_W-1:0] cnt_q;
   logic [N_EVT-1:0][CNT_W-1:0] cnt_nx;

   assign evt[EV_READ]  = rd_evt_i;
   assign evt[EV_WRITE] = wr_evt_i;
   assign evt[EV_CONFL] = bank_conf_i;

   for (genvar g = 0; g < N_EVT; g++) begin : g_cnt
      throttle_evt_counter #(
         .CNT_W    (CNT_W),
         .SATURATE (SATURATE)
      ) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .evt_i   (evt[g]),
         .clear_i (ep_last),
         .count_o (cnt_q[g]),
         .next_o  (cnt_nx[g])
      );
   end

   // ---------------- linear model ----------------
   logic [T_W-1:0] t_new;
   logic           t_new_vld;

   throttle_lin_model #(
      .PWR_W     (PWR_W),
      .CNT_W     (CNT_W),
      .COEF_W    (COEF_W),
      .FRAC_BITS (FRAC_BITS),
      .T_MAX     (WINDOW_LEN),
      .T_W       (T_W),
      .PIPE      (MODEL_PIPE)
   ) u_model (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_i   (ep_last),
      .pwr_i   (power_target_i),
      .cnt_i   (cnt_nx),
      .coef_i  (coef_vec_i),
      .t_o     (t_new),
      .t_vld_o (t_new_vld)
   );

   // ---------------- window stall ----------------
   logic [WIN_W-1:0] win_pos;

   throttle_window_gen #(
      .WINDOW_LEN (WINDOW_LEN),
      .T_W        (T_W),
      .WIN_W      (WIN_W)
   ) u_win (
      .clk         (clk),
      .rst_n       (rst_n),
      .t_new_i     (t_new),
      .t_new_vld_i (t_new_vld),
      .stall_o     (stall_o),
      .t_cur_o     (t_cur_o),
      .win_pos_o   (win_pos)
   );

endmodule

// File: rtl/mem_throttle_chk.sv
module mem_throttle_chk
   import throttle_pkg::*;
#(
   parameter int WINDOW_LEN = 10000,
   parameter int CNT_W      = 20,
   parameter int T_W        = 14,
   parameter int WIN_W      = 14,
   parameter bit SATURATE   = 1'b1
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        stall,
   input logic [T_W-1:0]              t_cur,
   input logic [WIN_W-1:0]            win_pos,
   input logic                        ep_last,
   input logic [N_EVT-1:0][CNT_W-1:0] cnt
);

   AST_ZERO_T_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (t_cur == '0) |-> !stall); // R2

   AST_STALL_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      ((win_pos == '0) && (t_cur != '0)) |-> stall); // R2

   AST_STALL_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && (win_pos != WIN_W'(WINDOW_LEN - 1))) |=> !stall); // R2

   AST_T_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (t_cur <= T_W'(WINDOW_LEN))); // R6

   AST_T_HELD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (win_pos != '0) |-> $stable(t_cur)); // R7

   AST_EPOCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ep_last |=> (cnt == '0)); // R4

   if (SATURATE) begin : g_sat_chk
      for (genvar g = 0; g < N_EVT; g++) begin : g_evt
         AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            ((cnt[g] == '1) && !ep_last) |=> (cnt[g] == '1)); // R5
      end
   end

endmodule

bind mem_throttle mem_throttle_chk #(
   .WINDOW_LEN (WINDOW_LEN),
   .CNT_W      (CNT_W),
   .T_W        (T_W),
   .WIN_W      (WIN_W),
   .SATURATE   (SATURATE)
) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .stall   (stall_o),
   .t_cur   (t_cur_o),
   .win_pos (win_pos),
   .ep_last (ep_last),
   .cnt     (cnt_q)
);

// File: tb/test_mem_throttle.sv
`timescale 1ns/1ps
module test_mem_throttle;

   localparam int WIN    = 16;
   localparam int EP     = 128;
   localparam int CW     = 6;
   localparam int PW     = 8;
   localparam int KW     = 12;
   localparam int FRAC   = 2;
   localparam int TW     = $clog2(WIN + 1);
   localparam int CMAX   = (1 << CW) - 1;
   localparam int N_CYC  = 900;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [PW-1:0]   pwr;
   logic            rd, wr, cf;
   logic [5*KW-1:0] coef_vec;
   logic            stall;
   logic [TW-1:0]   t_cur;

   int c_int [5];
   int pwr_int;
   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mem_throttle #(
      .WINDOW_LEN (WIN),
      .EPOCH_LEN  (EP),
      .CNT_W      (CW),
      .PWR_W      (PW),
      .COEF_W     (KW),
      .FRAC_BITS  (FRAC)
   ) i_mem_throttle (
      .clk            (clk),
      .rst_n          (rst_n),
      .power_target_i (pwr),
      .rd_evt_i       (rd),
      .wr_evt_i       (wr),
      .bank_conf_i    (cf),
      .coef_vec_i     (coef_vec),
      .stall_o        (stall),
      .t_cur_o        (t_cur)
   );

   // ---------------- behavioural reference ----------------
   int  k = 0;
   int  m_cnt [3] = '{0, 0, 0};
   int  m_tcur = 0;
   int  m_tpend = 0;
   bit  m_pend = 1'b0;
   int  m_ready = 0;

   always @(posedge clk) begin
      if (rst_n) begin
         int nx [3];
         int ev [3];
         int acc;
         int tv;
         if ((k % WIN) == WIN - 1 && m_pend && k >= m_ready) begin
            m_tcur = m_tpend;
            m_pend = 1'b0;
         end
         ev[0] = int'(rd);
         ev[1] = int'(wr);
         ev[2] = int'(cf);
         for (int e = 0; e < 3; e++) begin
            nx[e] = (m_cnt[e] + ev[e] > CMAX) ? CMAX : m_cnt[e] + ev[e];
         end
         if ((k % EP) == EP - 1) begin
            acc = c_int[0] + c_int[1] * pwr_int + c_int[2] * nx[0]
                + c_int[3] * nx[1] + c_int[4] * nx[2];
            tv  = acc >>> FRAC;
            if (tv < 0) tv = 0;
            if (tv > WIN) tv = WIN;
            m_tpend = tv;
            m_pend  = 1'b1;
            m_ready = k + 3;
            for (int e = 0; e < 3; e++) m_cnt[e] = 0;
         end else begin
            for (int e = 0; e < 3; e++) m_cnt[e] = nx[e];
         end
         k = k + 1;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, what, k, act, exp);
      end
   endtask

   task automatic set_coefs(input int c0, input int c1, input int c2, input int c3, input int c4);
      c_int[0] = c0; c_int[1] = c1; c_int[2] = c2; c_int[3] = c3; c_int[4] = c4;
      for (int i = 0; i < 5; i++) coef_vec[i*KW +: KW] = KW'(c_int[i]);
   endtask

   task automatic set_pwr(input int p);
      pwr_int = p;
      pwr     = PW'(p);
   endtask

   // stimulus for cycle c
   task automatic drive(input int c);
      int e;
      int o;
      e = c / EP;
      o = c % EP;
      rd = 1'b0; wr = 1'b0; cf = 1'b0;
      case (e)
         0: begin
            set_pwr(100); set_coefs(-40, 1, -2, 3, -1);
            rd = (o % 4 == 0); wr = (o % 8 == 0); cf = (o % 16 == 0);
         end
         1: begin
            set_pwr(100); set_coefs(0, 0, 0, 0, -4);
            cf = 1'b1;
         end
         2: begin
            set_pwr(0); set_coefs(0, 0, 1, 0, 0);
            rd = 1'b1; wr = 1'b1; cf = 1'b1;
         end
         3: begin
            set_pwr(0); set_coefs(400, 0, 0, 0, 0);
         end
         4: begin
            if (o < 64) begin set_pwr(200); set_coefs(2000, 1, 0, 0, 0); end
            else        begin set_pwr(8);   set_coefs(20, 1, 0, 0, 0);   end
         end
         5: begin
            set_pwr(50); set_coefs(-10, 1, 1, -1, -2);
            rd = (o % 3 == 0) || (o == EP - 1); wr = (o % 5 == 0); cf = (o % 7 == 0);
         end
         default: begin
            set_pwr(0); set_coefs(0, 0, 0, 0, 0);
         end
      endcase
   endtask

   // ---------------- main sequence ----------------
   initial begin
      rd = 1'b0; wr = 1'b0; cf = 1'b0;
      set_pwr(0);
      set_coefs(0, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      for (int c = 0; c < N_CYC; c++) begin
         if (c > 0) @(negedge clk);
         rst_n = 1'b1;
         chk("R2", "cycle index", k, c);
         chk("R2", "stall_o vs reference", int'(stall), int'((k % WIN) < m_tcur));
         chk("R3", "t_cur_o vs reference", int'(t_cur), m_tcur);
         case (c)
            0:   begin chk("R1", "t_cur_o after reset", int'(t_cur), 0);
                       chk("R1", "stall_o after reset", int'(stall), 0); end
            100: chk("R1", "t_cur_o in first epoch", int'(t_cur), 0);
            143: chk("R7", "t_cur_o before boundary", int'(t_cur), 0);
            144: chk("R3", "t_cur_o first model result", int'(t_cur), 9);
            152: chk("R2", "stall_o at position T-1", int'(stall), 1);
            153: chk("R2", "stall_o at position T", int'(stall), 0);
            160: chk("R2", "stall_o at window start", int'(stall), 1);
            271: chk("R7", "t_cur_o held until boundary", int'(t_cur), 9);
            272: begin chk("R6", "t_cur_o low clamp", int'(t_cur), 0);
                       chk("R6", "stall_o with T zero", int'(stall), 0); end
            400: chk("R5", "t_cur_o from saturated reads", int'(t_cur), 15);
            528: chk("R6", "t_cur_o high clamp", int'(t_cur), WIN);
            656: chk("R8", "t_cur_o from end-of-epoch sampling", int'(t_cur), 7);
            784: chk("R4", "t_cur_o with last-cycle read", int'(t_cur), 5);
            default: ;
         endcase
         if (c >= 528 && c < 528 + WIN) chk("R6", "stall_o across full window", int'(stall), 1);
         drive(c);
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   // ---------------- watchdog ----------------
   initial begin
      #((N_CYC + 200) * 4);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule